// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation entries from memory. A caller presents a linear address together with the physical base of the page directory. The walker fetches the directory entry, and, unless that entry describes a large page, it then fetches one entry from the page table named by the directory entry. It returns either the physical address or a fault tagged with the level whose entry was not present.

Every entry is a 32-bit word, and each table holds 1024 of them. A memory read port with a request/acknowledge handshake carries the fetches, with one read in flight at a time. A mode input enables large pages, which map a 4 MiB frame from the directory level in a single read. The walker captures the directory base and the mode input when it accepts a request, so later changes on those inputs do not disturb a walk in progress.

Top module: `pgw_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `mem_req` and `res_valid` are low.
- R2: When `req_valid` is high and the walker is idle, the request is accepted at that clock edge. `busy` is high from the next cycle up to the cycle before `res_valid`. A `req_valid` seen while `busy` is high is ignored.
- R3: The first read goes to address {dir_base[31:12], la[31:22], 2'b00}. Bits 11:0 of the directory base have no effect.
- R4: Bit 0 of an entry is the present flag. A directory entry with bit 0 clear ends the walk after one read with `res_fault`=1, `res_fault_lvl`=0 and `res_paddr`=0.
- R5: For a directory entry that points to a table, the second read goes to address {dir_entry[31:12], la[21:12], 2'b00}. If that table entry has bit 0 clear, the result is `res_fault`=1, `res_fault_lvl`=1 and `res_paddr`=0.
- R6: A present table entry gives `res_paddr` = {tbl_entry[31:12], la[11:0]}, with `res_fault`=0 and `res_large`=0.
- R7: With large pages enabled, a present directory entry that has bit 7 set ends the walk after one read. The result is `res_paddr` = {dir_entry[31:22], la[21:0]}, with `res_large`=1 and `res_fault`=0.
- R8: With large pages disabled, bit 7 of the directory entry is ignored, and the entry is treated as a pointer to a page table.
- R9: The directory base and the large-page enable are sampled when the request is accepted. Changing them during the walk does not change the walk.
- R10: `mem_req` stays high, with `mem_addr` stable, until the cycle in which `mem_ack` is high. The read data is taken in that cycle. At most one read is outstanding.
- R11: `res_valid` is a one-cycle pulse in the cycle after the final acknowledge. `res_paddr`, `res_fault`, `res_fault_lvl` and `res_large` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 32 | Linear address to translate |
| cfg_dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| cfg_large_en | input | 1 | Enables 4 MiB pages at the directory level |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge; data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended on a non-present entry |
| res_fault_lvl | output | 1 | Level that faulted: 0 = directory, 1 = table |
| res_large | output | 1 | Translation used a 4 MiB page |
| res_paddr | output | 32 | Physical address (zero on a fault) |

## Verification
The assertions rely on the memory side acknowledging only while `mem_req` is high, and only with a single-cycle pulse for each read. The bench's memory responder keeps to this. It waits a programmable number of cycles after it sees a request, raises `mem_ack` for exactly one cycle, and stays quiet until a new request appears. The requester is assumed to drive `req_valid` freely, so the bench deliberately raises it during walks. It also flips the directory base and the mode input right after acceptance, which exercises the capture rule.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/pgw_entry_dec.sv
module pgw_entry_dec #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int P_BIT     = 0,
  parameter int L_BIT     = 7
) (
  input  logic [ADDR_W-1:0]       entry,
  input  logic                    large_en,
  input  logic                    at_dir,
  output logic                    present,
  output logic                    is_large,
  output logic [ADDR_W-OFF_W-1:0] frame
);
  logic unused_flag_bits;

  assign present  = entry[P_BIT];
  assign is_large = at_dir & large_en & entry[L_BIT];
  assign frame    = entry[ADDR_W-1:OFF_W];
  assign unused_flag_bits = ^entry[OFF_W-1:0];
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2,
  localparam int FRAME_W  = ADDR_W - OFF_W,
  localparam int LG_OFF_W = OFF_W + IDX_W
) (
  input  logic [ADDR_W-1:0]   dir_base,
  input  logic [IDX_W-1:0]    dir_idx,
  input  logic [LG_OFF_W-1:0] walk_la,
  input  logic [FRAME_W-1:0]  frame,
  output logic [ADDR_W-1:0]   dir_addr,
  output logic [ADDR_W-1:0]   tbl_addr,
  output logic [ADDR_W-1:0]   pa_small,
  output logic [ADDR_W-1:0]   pa_large
);
  logic unused_base_low;

  assign dir_addr = {dir_base[ADDR_W-1:OFF_W], dir_idx, {ENT_LG{1'b0}}};
  assign tbl_addr = {frame, walk_la[LG_OFF_W-1:OFF_W], {ENT_LG{1'b0}}};
  assign pa_small = {frame, walk_la[OFF_W-1:0]};
  assign pa_large = {frame[FRAME_W-1:IDX_W], walk_la};
  assign unused_base_low = ^dir_base[OFF_W-1:0];
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int ENT_LG = 2,
  parameter int P_BIT  = 0,
  parameter int L_BIT  = 7,
  localparam int OFF_W    = IDX_W + ENT_LG,
  localparam int LG_OFF_W = OFF_W + IDX_W,
  localparam int FRAME_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic [ADDR_W-1:0] cfg_dir_base,
  input  logic              cfg_large_en,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic              res_fault,
  output logic              res_fault_lvl,
  output logic              res_large,
  output logic [ADDR_W-1:0] res_paddr
);
  walk_state_e state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [LG_OFF_W-1:0] la_q;
  logic                lg_q;
  logic                ld_req, ld_res;
  logic                rv_q, rv_d;
  logic                rf_d, rl_d, rlg_d;
  logic [ADDR_W-1:0]   rpa_d;
  logic                rf_q, rl_q, rlg_q;
  logic [ADDR_W-1:0]   rpa_q;

  logic                ent_present, ent_large;
  logic [FRAME_W-1:0]  ent_frame;
  logic [ADDR_W-1:0]   dir_addr, tbl_addr, pa_small, pa_large;

  pgw_entry_dec #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W), .P_BIT (P_BIT), .L_BIT (L_BIT)
  ) u_dec (
    .entry    (mem_rdata),
    .large_en (lg_q),
    .at_dir   (state_q == ST_DIR),
    .present  (ent_present),
    .is_large (ent_large),
    .frame    (ent_frame)
  );

  pgw_addr_gen #(
    .ADDR_W (ADDR_W), .IDX_W (IDX_W), .OFF_W (OFF_W), .ENT_LG (ENT_LG)
  ) u_agen (
    .dir_base (cfg_dir_base),
    .dir_idx  (req_laddr[ADDR_W-1:LG_OFF_W]),
    .walk_la  (la_q),
    .frame    (ent_frame),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr),
    .pa_small (pa_small),
    .pa_large (pa_large)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    ld_req  = 1'b0;
    ld_res  = 1'b0;
    rv_d    = 1'b0;
    rf_d    = 1'b0;
    rl_d    = 1'b0;
    rlg_d   = 1'b0;
    rpa_d   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_DIR;
          addr_d  = dir_addr;
          ld_req  = 1'b1;
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (!ent_present) begin
            state_d = ST_IDLE;
            ld_res  = 1'b1;
            rv_d    = 1'b1;
            rf_d    = 1'b1;
          end else if (ent_large) begin
            state_d = ST_IDLE;
            ld_res  = 1'b1;
            rv_d    = 1'b1;
            rlg_d   = 1'b1;
            rpa_d   = pa_large;
          end else begin
            state_d = ST_TBL;
            addr_d  = tbl_addr;
          end
        end
      end
      ST_TBL: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
          ld_res  = 1'b1;
          rv_d    = 1'b1;
          rl_d    = 1'b1;
          if (!ent_present) rf_d  = 1'b1;
          else              rpa_d = pa_small;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_req) begin
      la_q <= req_laddr[LG_OFF_W-1:0];
      lg_q <= cfg_large_en;
    end
    if (ld_req || (state_q == ST_DIR && mem_ack))
      addr_q <= addr_d;
    if (ld_res) begin
      rf_q  <= rf_d;
      rl_q  <= rl_d;
      rlg_q <= rlg_d;
      rpa_q <= rpa_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req       = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign mem_addr      = addr_q;
  assign res_valid     = rv_q;
  assign res_fault     = rf_q;
  assign res_fault_lvl = rl_q;
  assign res_large     = rlg_q;
  assign res_paddr     = rpa_q;

  // R10: a pending read holds its address until acknowledged
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R2: a walk only begins after a request
  a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R11: result follows an acknowledge of a walk in progress
  a_r11_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_ack) && $past(busy));

  // R11: result is a single-cycle pulse
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2: result is reported once the walker is idle again
  a_r2_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);

  // R4: faults report a zero address
  a_r4_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0);

  // R7: large pages never report a fault
  a_r7_large_ok: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_large |-> !res_fault);
endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, cfg_large_en;
  logic [31:0] req_laddr, cfg_dir_base;
  logic        busy, mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        res_valid, res_fault, res_fault_lvl, res_large;
  logic [31:0] res_paddr;

  pgw_walker i_pgw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
    .cfg_dir_base(cfg_dir_base), .cfg_large_en(cfg_large_en), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_fault(res_fault), .res_fault_lvl(res_fault_lvl),
    .res_large(res_large), .res_paddr(res_paddr)
  );

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  int cycles = 0;
  bit done = 0;
  bit model_busy = 0;
  bit acc = 0;
  bit running = 0;
  string cur_tag = "";

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_q [$];
  logic [31:0] exp_pa;
  logic        exp_f, exp_lvl, exp_lg;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // behavioural reference: expected reads and result
  task automatic model(input logic [31:0] la, input logic [31:0] base, input bit en);
    logic [31:0] da, de, ta, te;
    da = (base & 32'hFFFF_F000) + (la >> 22) * 4;
    de = rd(da);
    exp_q.push_back(da);
    exp_pa = 0; exp_f = 0; exp_lvl = 0; exp_lg = 0;
    if (de[0] == 1'b0) begin
      exp_f = 1;
    end else if (en && de[7]) begin
      exp_lg = 1;
      exp_pa = (de & 32'hFFC0_0000) | (la & 32'h003F_FFFF);
    end else begin
      ta = (de & 32'hFFFF_F000) + ((la >> 12) & 32'h3FF) * 4;
      te = rd(ta);
      exp_q.push_back(ta);
      exp_lvl = 1;
      if (te[0] == 1'b0) exp_f = 1;
      else exp_pa = (te & 32'hFFFF_F000) | (la & 32'hFFF);
    end
  endtask

  // memory responder and read-address checker (R3 R5 R10)
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1;
        mem_rdata = rd(mem_addr);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 extra read actual=%h expected=none", mem_addr);
        end else begin
          chk({cur_tag, " R3 R5 R10 read address"}, mem_addr, exp_q.pop_front());
        end
      end else begin
        cnt++;
      end
    end
  end

  always @(posedge clk) acc <= rst_n && req_valid && !model_busy;

  // per-clock comparison of busy and results (R2 R11)
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (acc) model_busy = 1;
      if (res_valid) model_busy = 0;
      chk({cur_tag, " R2 busy"}, {31'b0, busy}, {31'b0, model_busy});
      if (res_valid) begin
        chk({cur_tag, " R11 fault"}, {31'b0, res_fault}, {31'b0, exp_f});
        if (exp_f) chk({cur_tag, " R11 fault level"}, {31'b0, res_fault_lvl}, {31'b0, exp_lvl});
        chk({cur_tag, " R11 large"}, {31'b0, res_large}, {31'b0, exp_lg});
        chk({cur_tag, " R11 paddr"}, res_paddr, exp_pa);
        done = 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic walk(input string tag, input logic [31:0] la, input logic [31:0] base,
                      input bit en, input bit junk);
    cur_tag = tag;
    model(la, base, en);
    done = 0;
    @(negedge clk);
    req_valid = 1; req_laddr = la; cfg_dir_base = base; cfg_large_en = en;
    @(negedge clk);
    // R9: disturb config after acceptance; R2: extra request while busy
    req_valid = junk; req_laddr = ~la; cfg_dir_base = ~base; cfg_large_en = ~en;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    chk({tag, " R10 all reads issued"}, exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_laddr = 0; cfg_dir_base = 0; cfg_large_en = 0;
    mem_ack = 0; mem_rdata = 0;
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h1234_5001;
    mem[32'h0001_0008] = 32'h0003_0000;
    mem[32'h0002_0010] = 32'h5555_5000;
    mem[32'h0001_000C] = 32'h4080_0081;
    mem[32'h4080_0048] = 32'h7000_0001;
    mem[32'h0001_0010] = 32'h0000_0080;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 0);
    chk("R1 mem_req in reset", {31'b0, mem_req}, 0);
    chk("R1 res_valid in reset", {31'b0, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", {31'b0, busy}, 0);
    chk("R1 mem_req after reset", {31'b0, mem_req}, 0);
    running = 1;

    lat = 0; walk("R6 4K page", 32'h0040_3ABC, 32'h0001_0000, 0, 0);      // 12345abc
    lat = 2; walk("R6 4K page slow", 32'h0040_3ABC, 32'h0001_0000, 1, 1);
    lat = 1; walk("R4 dir absent", 32'h0080_0000, 32'h0001_0000, 1, 0);
    lat = 3; walk("R5 table absent", 32'h0040_4000, 32'h0001_0000, 0, 1);
    lat = 0; walk("R7 large page", 32'h00C1_2345, 32'h0001_0000, 1, 1);  // 40812345
    lat = 2; walk("R7 large page slow", 32'h00FF_FFFF, 32'h0001_0000, 1, 0);
    lat = 1; walk("R8 large bit off", 32'h00C1_2345, 32'h0001_0000, 0, 1); // 70000345
    lat = 0; walk("R3 base low bits", 32'h0040_3ABC, 32'h0001_0FFF, 0, 0);
    lat = 1; walk("R9 cfg sampled", 32'h00C1_2345, 32'h0001_0000, 1, 1);
    lat = 0; walk("R4 large flag absent", 32'h0100_0000, 32'h0001_0000, 1, 0);
    lat = 3; walk("R10 unmapped", 32'hFFC0_0000, 32'h0001_0000, 0, 1);

    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule